// File: doc/BRIEF.md
# Translation Buffer Invalidation Controller

This block owns the valid bits of a two-level address translation buffer and carries out every request to invalidate entries in it. The second level holds a small fully associative array, whose entries have a page-size code and a protect flag, and a set-associative array of fixed-size pages. The first level keeps its own copies of page numbers. A loading port fills entries so that the state can be set up and observed.

Three kinds of invalidation are supported. An address request clears the entries that translate a given effective page number and may raise a broadcast pulse for other bus agents. A precise request drops the valid bit of one named entry. A flash request clears a whole second-level array after control bits are written. Protected entries in the fully associative array survive address requests. Any second-level entry that is actually removed also removes the first-level copies of the same page.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: After reset, every valid bit, the broadcast outputs and both flash pending bits are 0.
- R2: With `load_en`=1, the entry is written and marked valid on the next clock edge. `load_arr` selects the array: 0 is the fully associative array, 1 is the set-associative array and 2 is the first level. A fully associative or first-level entry is written at index `load_idx`. A set-associative entry is written at flat index set*WAYS+way, where set is the low bits of `load_epn` and way is the low bits of `load_idx`.
- R3: An address request (`req_kind`=0) clears several kinds of entry. It clears every valid, unprotected fully associative entry whose page number equals `req_ea` once the low 2*size bits are masked. It also clears every valid set-associative entry in set `req_ea` low bits whose page number equals `req_ea` exactly. The clear shows on the next edge.
- R4: A protected fully associative entry that matches an address request stays valid.
- R5: The protect input has no effect on set-associative and first-level entries, so an address request clears them.
- R6: A precise request (`req_kind`=1) clears the entry at flat index `req_idx` in the array chosen by `req_arr` (same encoding as R2). It does this even when the entry is protected.
- R7: An address request that clears at least one second-level entry also clears the first-level entries whose page equals `req_ea`. A precise request on a valid second-level entry also clears the first-level entries that match that entry's page under its mask. In every other case the first level is untouched.
- R8: Each address request taken while `bcast_en`=1 gives `bcast`=1 for exactly the following cycle, with `bcast_ea` equal to `req_ea`, whether or not anything matched. Precise requests, flash requests and `bcast_en`=0 give no pulse. `bcast_ea` is 0 when there is no pulse.
- R9: `ctl_wr` loads `ctl_wdata` into `flash_pend`, where bit 0 selects the fully associative array and bit 1 the set-associative array. On the next edge the selected arrays and the whole first level are cleared and `flash_pend` returns to 0 unless written again.
- R10: When several things happen in the same cycle, a flash that is executing drops any request or load, and a request drops any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bcast_en | input | 1 | Enables the broadcast pulse for address requests |
| ctl_wr | input | 1 | Writes the flash control bits |
| ctl_wdata | input | 2 | Flash select: bit 0 fully associative, bit 1 set-associative |
| req_valid | input | 1 | Invalidation request strobe |
| req_kind | input | 1 | 0 address, 1 precise |
| req_arr | input | 2 | Target array for precise requests |
| req_idx | input | IDX_W | Flat entry index for precise requests |
| req_ea | input | EPN_W | Effective page number for address requests |
| load_en | input | 1 | Entry load strobe |
| load_arr | input | 2 | Target array of the load |
| load_idx | input | IDX_W | Entry index (way for the set-associative array) |
| load_epn | input | EPN_W | Page number to store |
| load_size | input | SZ_W | Page-size code (fully associative only) |
| load_prot | input | 1 | Protect flag (fully associative only) |
| fa_valid | output | NFA | Valid bits of the fully associative array |
| sa_valid | output | SA_SETS*SA_WAYS | Valid bits of the set-associative array |
| l1_valid | output | NL1 | Valid bits of the first-level copies |
| flash_pend | output | 2 | Flash control bits waiting to execute |
| bcast | output | 1 | Broadcast pulse |
| bcast_ea | output | EPN_W | Page number carried with the pulse |

## Verification
A wrong stored page number or size code does not change any valid bit by itself. It shows up only when a later address request clears the wrong entry or fails to clear the right one, one edge after that request. A wrong protect flag shows the same way, or as a first-level copy that lives or dies wrongly in the same cycle. A flash pending bit stuck high keeps the selected array empty on every following edge. The bench therefore mirrors all entry state and compares every valid vector and the broadcast outputs after each cycle, over long random sequences that draw page numbers from a small pool so that matches are frequent.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
    typedef enum logic [1:0] {
        ARR_FA = 2'd0,
        ARR_SA = 2'd1,
        ARR_L1 = 2'd2,
        ARR_NONE = 2'd3
    } arr_e;

    typedef enum logic {
        REQ_ADDR    = 1'b0,
        REQ_PRECISE = 1'b1
    } kind_e;
endpackage

// File: rtl/tlbi_fa_bank.sv
module tlbi_fa_bank #(
    parameter int N     = 8,
    parameter int EPN_W = 16,
    parameter int SZ_W  = 2,
    localparam int LW   = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flash,
    input  logic             inv_addr,
    input  logic             inv_prec,
    input  logic [LW-1:0]    idx,
    input  logic [EPN_W-1:0] ea,
    input  logic             ld,
    input  logic [LW-1:0]    ld_idx,
    input  logic [EPN_W-1:0] ld_epn,
    input  logic [SZ_W-1:0]  ld_size,
    input  logic             ld_prot,
    output logic [N-1:0]     vld,
    output logic             hit_clr,
    output logic             sel_live,
    output logic [EPN_W-1:0] sel_epn,
    output logic [EPN_W-1:0] sel_mask
);
    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0]            prot;
        logic [N-1:0][EPN_W-1:0] epn;
        logic [N-1:0][SZ_W-1:0]  sz;
    } fa_st_t;

    fa_st_t st_d, st_q;
    logic [N-1:0] kill;

    function automatic logic [EPN_W-1:0] size_mask(input logic [SZ_W-1:0] s);
        return {EPN_W{1'b1}} << (2 * s);
    endfunction

    for (genvar i = 0; i < N; i++) begin : g_match
        assign kill[i] = st_q.vld[i] && !st_q.prot[i]
                       && (((st_q.epn[i] ^ ea) & size_mask(st_q.sz[i])) == '0);
    end

    always_comb begin
        st_d = st_q;
        if (flash) begin
            st_d.vld = '0;
        end else if (inv_addr) begin
            st_d.vld = st_q.vld & ~kill;
        end else if (inv_prec) begin
            st_d.vld[idx] = 1'b0;
        end else if (ld) begin
            st_d.vld[ld_idx]  = 1'b1;
            st_d.prot[ld_idx] = ld_prot;
            st_d.epn[ld_idx]  = ld_epn;
            st_d.sz[ld_idx]   = ld_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld      = st_q.vld;
    assign hit_clr  = inv_addr && (|kill);
    assign sel_live = st_q.vld[idx];
    assign sel_epn  = st_q.epn[idx];
    assign sel_mask = size_mask(st_q.sz[idx]);

    // R4
    prot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_addr && !flash) |=> ((st_q.vld & st_q.prot) == $past(st_q.vld & st_q.prot)));
endmodule

// File: rtl/tlbi_sa_bank.sv
module tlbi_sa_bank #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int EPN_W = 16,
    localparam int N    = SETS * WAYS,
    localparam int SW   = $clog2(SETS),
    localparam int WW   = $clog2(WAYS),
    localparam int LW   = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flash,
    input  logic             inv_addr,
    input  logic             inv_prec,
    input  logic [LW-1:0]    idx,
    input  logic [EPN_W-1:0] ea,
    input  logic             ld,
    input  logic [WW-1:0]    ld_way,
    input  logic [EPN_W-1:0] ld_epn,
    output logic [N-1:0]     vld,
    output logic             hit_clr,
    output logic             sel_live,
    output logic [EPN_W-1:0] sel_epn
);
    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][EPN_W-1:0] epn;
    } sa_st_t;

    sa_st_t st_d, st_q;
    logic [N-1:0] kill;
    logic [LW-1:0] ld_slot;

    for (genvar i = 0; i < N; i++) begin : g_match
        localparam int SET_OF = i / WAYS;
        assign kill[i] = st_q.vld[i] && (st_q.epn[i] == ea)
                       && (ea[SW-1:0] == SET_OF[SW-1:0]);

        // R3
        sa_other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_addr && !flash && st_q.vld[i] && (st_q.epn[i] != ea)) |=> st_q.vld[i]);
    end

    assign ld_slot = {ld_epn[SW-1:0], ld_way};

    always_comb begin
        st_d = st_q;
        if (flash) begin
            st_d.vld = '0;
        end else if (inv_addr) begin
            st_d.vld = st_q.vld & ~kill;
        end else if (inv_prec) begin
            st_d.vld[idx] = 1'b0;
        end else if (ld) begin
            st_d.vld[ld_slot] = 1'b1;
            st_d.epn[ld_slot] = ld_epn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld      = st_q.vld;
    assign hit_clr  = inv_addr && (|kill);
    assign sel_live = st_q.vld[idx];
    assign sel_epn  = st_q.epn[idx];
endmodule

// File: rtl/tlbi_l1_bank.sv
module tlbi_l1_bank #(
    parameter int N     = 4,
    parameter int EPN_W = 16,
    localparam int LW   = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flash,
    input  logic             kill,
    input  logic [EPN_W-1:0] kill_epn,
    input  logic [EPN_W-1:0] kill_mask,
    input  logic             prec,
    input  logic [LW-1:0]    idx,
    input  logic             ld,
    input  logic [LW-1:0]    ld_idx,
    input  logic [EPN_W-1:0] ld_epn,
    output logic [N-1:0]     vld
);
    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][EPN_W-1:0] epn;
    } l1_st_t;

    l1_st_t st_d, st_q;
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_match
        assign hit[i] = ((st_q.epn[i] ^ kill_epn) & kill_mask) == '0;
    end

    always_comb begin
        st_d = st_q;
        if (flash) begin
            st_d.vld = '0;
        end else if (kill) begin
            st_d.vld = st_q.vld & ~hit;
        end else if (prec) begin
            st_d.vld[idx] = 1'b0;
        end else if (ld) begin
            st_d.vld[ld_idx] = 1'b1;
            st_d.epn[ld_idx] = ld_epn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld = st_q.vld;

    // R7
    l1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash && !kill && !prec && !ld) |=> (st_q.vld == $past(st_q.vld)));
endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl
    import tlbi_pkg::*;
#(
    parameter int NFA     = 8,
    parameter int SA_SETS = 4,
    parameter int SA_WAYS = 2,
    parameter int NL1     = 4,
    parameter int EPN_W   = 16,
    parameter int SZ_W    = 2,
    localparam int NSA    = SA_SETS * SA_WAYS,
    localparam int NMAX   = (NFA > NSA) ? ((NFA > NL1) ? NFA : NL1) : ((NSA > NL1) ? NSA : NL1),
    localparam int IDX_W  = $clog2(NMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bcast_en,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_wdata,
    input  logic             req_valid,
    input  logic             req_kind,
    input  logic [1:0]       req_arr,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [EPN_W-1:0] req_ea,
    input  logic             load_en,
    input  logic [1:0]       load_arr,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [EPN_W-1:0] load_epn,
    input  logic [SZ_W-1:0]  load_size,
    input  logic             load_prot,
    output logic [NFA-1:0]   fa_valid,
    output logic [NSA-1:0]   sa_valid,
    output logic [NL1-1:0]   l1_valid,
    output logic [1:0]       flash_pend,
    output logic             bcast,
    output logic [EPN_W-1:0] bcast_ea
);
    localparam int FA_LW = $clog2(NFA);
    localparam int SA_LW = $clog2(NSA);
    localparam int SA_WW = $clog2(SA_WAYS);
    localparam int L1_LW = $clog2(NL1);

    typedef struct packed {
        logic [1:0]       pend;
        logic             bc;
        logic [EPN_W-1:0] bc_ea;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    kind_e kind;
    arr_e  rarr, larr;
    logic  flash_go, req_go, ld_go, addr_go, prec_go;
    logic  fa_prec, sa_prec, l1_prec;
    logic  fa_ld, sa_ld, l1_ld;
    logic  fa_hit, sa_hit, fa_live, sa_live;
    logic  [EPN_W-1:0] fa_sel_epn, fa_sel_mask, sa_sel_epn;
    logic  l1_kill;
    logic  [EPN_W-1:0] l1_kill_epn, l1_kill_mask;

    assign kind = kind_e'(req_kind);
    assign rarr = arr_e'(req_arr);
    assign larr = arr_e'(load_arr);

    assign flash_go = |ctl_q.pend;
    assign req_go   = req_valid && !flash_go;
    assign ld_go    = load_en && !req_valid && !flash_go;
    assign addr_go  = req_go && (kind == REQ_ADDR);
    assign prec_go  = req_go && (kind == REQ_PRECISE);

    assign fa_prec = prec_go && (rarr == ARR_FA);
    assign sa_prec = prec_go && (rarr == ARR_SA);
    assign l1_prec = prec_go && (rarr == ARR_L1);
    assign fa_ld   = ld_go && (larr == ARR_FA);
    assign sa_ld   = ld_go && (larr == ARR_SA);
    assign l1_ld   = ld_go && (larr == ARR_L1);

    tlbi_fa_bank #(.N(NFA), .EPN_W(EPN_W), .SZ_W(SZ_W)) u_fa (
        .clk      (clk),
        .rst_n    (rst_n),
        .flash    (ctl_q.pend[0]),
        .inv_addr (addr_go),
        .inv_prec (fa_prec),
        .idx      (req_idx[FA_LW-1:0]),
        .ea       (req_ea),
        .ld       (fa_ld),
        .ld_idx   (load_idx[FA_LW-1:0]),
        .ld_epn   (load_epn),
        .ld_size  (load_size),
        .ld_prot  (load_prot),
        .vld      (fa_valid),
        .hit_clr  (fa_hit),
        .sel_live (fa_live),
        .sel_epn  (fa_sel_epn),
        .sel_mask (fa_sel_mask)
    );

    tlbi_sa_bank #(.SETS(SA_SETS), .WAYS(SA_WAYS), .EPN_W(EPN_W)) u_sa (
        .clk      (clk),
        .rst_n    (rst_n),
        .flash    (ctl_q.pend[1]),
        .inv_addr (addr_go),
        .inv_prec (sa_prec),
        .idx      (req_idx[SA_LW-1:0]),
        .ea       (req_ea),
        .ld       (sa_ld),
        .ld_way   (load_idx[SA_WW-1:0]),
        .ld_epn   (load_epn),
        .vld      (sa_valid),
        .hit_clr  (sa_hit),
        .sel_live (sa_live),
        .sel_epn  (sa_sel_epn)
    );

    always_comb begin
        if (addr_go) begin
            l1_kill      = fa_hit || sa_hit;
            l1_kill_epn  = req_ea;
            l1_kill_mask = '1;
        end else if (fa_prec) begin
            l1_kill      = fa_live;
            l1_kill_epn  = fa_sel_epn;
            l1_kill_mask = fa_sel_mask;
        end else begin
            l1_kill      = sa_prec && sa_live;
            l1_kill_epn  = sa_sel_epn;
            l1_kill_mask = '1;
        end
    end

    tlbi_l1_bank #(.N(NL1), .EPN_W(EPN_W)) u_l1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .flash     (flash_go),
        .kill      (l1_kill),
        .kill_epn  (l1_kill_epn),
        .kill_mask (l1_kill_mask),
        .prec      (l1_prec),
        .idx       (req_idx[L1_LW-1:0]),
        .ld        (l1_ld),
        .ld_idx    (load_idx[L1_LW-1:0]),
        .ld_epn    (load_epn),
        .vld       (l1_valid)
    );

    always_comb begin
        ctl_d.pend  = ctl_wr ? ctl_wdata : 2'b00;
        ctl_d.bc    = addr_go && bcast_en;
        ctl_d.bc_ea = (addr_go && bcast_en) ? req_ea : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign flash_pend = ctl_q.pend;
    assign bcast      = ctl_q.bc;
    assign bcast_ea   = ctl_q.bc_ea;

    // R8
    bcast_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_kind && bcast_en && (flash_pend == 2'b00))
        |=> (bcast && (bcast_ea == $past(req_ea))));

    // R8
    bcast_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_kind) |=> !bcast);

    // R9
    flash_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flash_pend) && !ctl_wr) |=> (flash_pend == 2'b00));

    // R9
    flash_fa_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_pend[0] |=> (fa_valid == '0));

    // R9
    flash_l1_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flash_pend) |=> (l1_valid == '0));
endmodule

// File: tb/tlb_inval_ctrl_test.sv
module tlb_inval_ctrl_test;
    localparam int NFA = 8, NSA = 8, NL1 = 4, WAYS = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bcast_en, ctl_wr, req_valid, req_kind, load_en, load_prot;
    logic [1:0]  ctl_wdata, req_arr, load_arr, load_size;
    logic [2:0]  req_idx, load_idx;
    logic [15:0] req_ea, load_epn;
    logic [7:0]  fa_valid, sa_valid;
    logic [3:0]  l1_valid;
    logic [1:0]  flash_pend;
    logic        bcast;
    logic [15:0] bcast_ea;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // bench mirror of the entry state
    bit          m_fa_v[NFA], m_fa_p[NFA];
    logic [15:0] m_fa_e[NFA];
    logic [1:0]  m_fa_s[NFA];
    bit          m_sa_v[NSA];
    logic [15:0] m_sa_e[NSA];
    bit          m_l1_v[NL1];
    logic [15:0] m_l1_e[NL1];
    logic [1:0]  m_pend;
    bit          m_bc;
    logic [15:0] m_bcea;

    tlb_inval_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bcast_en(bcast_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_arr(req_arr), .req_idx(req_idx),
        .req_ea(req_ea), .load_en(load_en), .load_arr(load_arr), .load_idx(load_idx),
        .load_epn(load_epn), .load_size(load_size), .load_prot(load_prot),
        .fa_valid(fa_valid), .sa_valid(sa_valid), .l1_valid(l1_valid),
        .flash_pend(flash_pend), .bcast(bcast), .bcast_ea(bcast_ea)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] pmask(input logic [1:0] s);
        return 16'hFFFF << (2 * s);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        ctl_wr = 0; ctl_wdata = 0; req_valid = 0; req_kind = 0; req_arr = 0; req_idx = 0;
        req_ea = 0; load_en = 0; load_arr = 0; load_idx = 0; load_epn = 0; load_size = 0;
        load_prot = 0;
    endtask

    task automatic l1_clear(input logic [15:0] e, input logic [15:0] mk);
        for (int i = 0; i < NL1; i++)
            if (((m_l1_e[i] ^ e) & mk) == 16'h0) m_l1_v[i] = 0;
    endtask

    task automatic model_step();
        bit succ;
        int slot;
        m_bc = 0; m_bcea = 16'h0;
        if (m_pend != 2'b00) begin
            if (m_pend[0]) for (int i = 0; i < NFA; i++) m_fa_v[i] = 0;
            if (m_pend[1]) for (int i = 0; i < NSA; i++) m_sa_v[i] = 0;
            for (int i = 0; i < NL1; i++) m_l1_v[i] = 0;
        end else if (req_valid) begin
            if (!req_kind) begin
                succ = 0;
                for (int i = 0; i < NFA; i++)
                    if (m_fa_v[i] && !m_fa_p[i] && (((m_fa_e[i] ^ req_ea) & pmask(m_fa_s[i])) == 16'h0)) begin
                        m_fa_v[i] = 0; succ = 1;
                    end
                for (int i = 0; i < NSA; i++)
                    if (m_sa_v[i] && m_sa_e[i] == req_ea && (i / WAYS) == int'(req_ea[1:0])) begin
                        m_sa_v[i] = 0; succ = 1;
                    end
                if (succ) l1_clear(req_ea, 16'hFFFF);
                if (bcast_en) begin m_bc = 1; m_bcea = req_ea; end
            end else begin
                if (req_arr == 2'd0) begin
                    if (m_fa_v[req_idx]) begin
                        l1_clear(m_fa_e[req_idx], pmask(m_fa_s[req_idx]));
                        m_fa_v[req_idx] = 0;
                    end
                end else if (req_arr == 2'd1) begin
                    if (m_sa_v[req_idx]) begin
                        l1_clear(m_sa_e[req_idx], 16'hFFFF);
                        m_sa_v[req_idx] = 0;
                    end
                end else if (req_arr == 2'd2) begin
                    m_l1_v[req_idx[1:0]] = 0;
                end
            end
        end else if (load_en) begin
            if (load_arr == 2'd0) begin
                m_fa_v[load_idx] = 1; m_fa_e[load_idx] = load_epn;
                m_fa_s[load_idx] = load_size; m_fa_p[load_idx] = load_prot;
            end else if (load_arr == 2'd1) begin
                slot = int'(load_epn[1:0]) * WAYS + int'(load_idx[0]);
                m_sa_v[slot] = 1; m_sa_e[slot] = load_epn;
            end else if (load_arr == 2'd2) begin
                m_l1_v[load_idx[1:0]] = 1; m_l1_e[load_idx[1:0]] = load_epn;
            end
        end
        m_pend = ctl_wr ? ctl_wdata : 2'b00;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] efa, esa;
        logic [3:0] el1;
        for (int i = 0; i < NFA; i++) efa[i] = m_fa_v[i];
        for (int i = 0; i < NSA; i++) esa[i] = m_sa_v[i];
        for (int i = 0; i < NL1; i++) el1[i] = m_l1_v[i];
        chk(tag, "fa_valid", {24'h0, fa_valid}, {24'h0, efa});
        chk(tag, "sa_valid", {24'h0, sa_valid}, {24'h0, esa});
        chk(tag, "l1_valid", {28'h0, l1_valid}, {28'h0, el1});
        chk(tag, "flash_pend", {30'h0, flash_pend}, {30'h0, m_pend});
        chk(tag, "bcast", {31'h0, bcast}, {31'h0, m_bc});
        chk(tag, "bcast_ea", {16'h0, bcast_ea}, {16'h0, m_bcea});
    endtask

    // inputs set by the caller at a falling edge; results sampled 5 ns after the rising edge
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        #5;
        check_all(tag);
        @(negedge clk);
        idle();
    endtask

    task automatic ld(input logic [1:0] a, input logic [2:0] i, input logic [15:0] e,
                      input logic [1:0] s, input logic p, input string tag);
        load_en = 1; load_arr = a; load_idx = i; load_epn = e; load_size = s; load_prot = p;
        tick(tag);
    endtask

    task automatic inv_a(input logic [15:0] e, input string tag);
        req_valid = 1; req_kind = 0; req_ea = e;
        tick(tag);
    endtask

    task automatic inv_p(input logic [1:0] a, input logic [2:0] i, input string tag);
        req_valid = 1; req_kind = 1; req_arr = a; req_idx = i;
        tick(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int op;
        seed = $urandom(32'd4711);
        idle();
        bcast_en = 1;
        rst_n = 0;
        for (int i = 0; i < NFA; i++) begin m_fa_v[i] = 0; m_fa_p[i] = 0; m_fa_e[i] = 0; m_fa_s[i] = 0; end
        for (int i = 0; i < NSA; i++) begin m_sa_v[i] = 0; m_sa_e[i] = 0; end
        for (int i = 0; i < NL1; i++) begin m_l1_v[i] = 0; m_l1_e[i] = 0; end
        m_pend = 0; m_bc = 0; m_bcea = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check_all("R1");

        // R2 loads into all three arrays
        ld(2'd0, 3'd3, 16'h1230, 2'd1, 1'b0, "R2");
        ld(2'd1, 3'd1, 16'h0042, 2'd0, 1'b0, "R2");
        ld(2'd2, 3'd0, 16'h1232, 2'd0, 1'b0, "R2");
        ld(2'd2, 3'd1, 16'h0042, 2'd0, 1'b0, "R2");
        // R3 masked match inside the page, R7 first-level copy follows, R8 pulse
        inv_a(16'h1232, "R3");
        inv_a(16'h0042, "R7");
        // R4 protected entry survives, first level untouched since nothing cleared
        ld(2'd0, 3'd5, 16'h0500, 2'd0, 1'b1, "R4");
        ld(2'd2, 3'd2, 16'h0500, 2'd0, 1'b0, "R4");
        inv_a(16'h0500, "R4");
        // R6 precise clear of the protected entry, R7 copy goes too
        inv_p(2'd0, 3'd5, "R6");
        // R5 protect flag ignored for set-associative and first level
        ld(2'd1, 3'd0, 16'h0013, 2'd0, 1'b1, "R5");
        ld(2'd2, 3'd3, 16'h0013, 2'd0, 1'b1, "R5");
        inv_a(16'h0013, "R5");
        // R8 no pulse when disabled, pulse on a miss when enabled
        bcast_en = 0;
        inv_a(16'h0777, "R8");
        bcast_en = 1;
        inv_a(16'h0777, "R8");
        inv_p(2'd1, 3'd2, "R8");
        // R9 flash of the fully associative array only
        ld(2'd0, 3'd0, 16'h0AAA, 2'd2, 1'b1, "R9");
        ld(2'd1, 3'd1, 16'h0021, 2'd0, 1'b0, "R9");
        ld(2'd2, 3'd0, 16'h0999, 2'd0, 1'b0, "R9");
        ctl_wr = 1; ctl_wdata = 2'b01;
        tick("R9");
        tick("R9");
        // R10 a request arriving during flash execution is dropped
        ld(2'd0, 3'd1, 16'h0300, 2'd0, 1'b0, "R10");
        ctl_wr = 1; ctl_wdata = 2'b10;
        tick("R10");
        req_valid = 1; req_kind = 0; req_ea = 16'h0300;
        tick("R10");
        // R10 a load with a request in the same cycle is dropped
        req_valid = 1; req_kind = 1; req_arr = 2'd2; req_idx = 3'd0;
        load_en = 1; load_arr = 2'd0; load_idx = 3'd6; load_epn = 16'h0123;
        tick("R10");

        // random mix drawing page numbers from a small pool
        for (int n = 0; n < 600; n++) begin
            op = int'($urandom % 16);
            bcast_en = ($urandom % 4) != 0;
            if (op < 7) begin
                load_en = 1; load_arr = 2'($urandom % 3); load_idx = 3'($urandom);
                load_epn = 16'h0A00 | 16'($urandom % 16); load_size = 2'($urandom % 3);
                load_prot = ($urandom % 4) == 0;
                tick("R2");
            end else if (op < 11) begin
                req_valid = 1; req_kind = 0; req_ea = 16'h0A00 | 16'($urandom % 16);
                if ($urandom % 5 == 0) begin load_en = 1; load_arr = 2'd0; load_idx = 3'($urandom); load_epn = 16'h0A05; end
                tick("R3");
            end else if (op < 14) begin
                req_valid = 1; req_kind = 1; req_arr = 2'($urandom % 4); req_idx = 3'($urandom);
                tick("R6");
            end else if (op == 14) begin
                ctl_wr = 1; ctl_wdata = 2'($urandom % 4);
                tick("R9");
            end else begin
                tick("R7");
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule